// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a single-port synchronous memory built so that reads and writes can follow each other on the data bus in any order without idle cycles. Every enabled rising clock edge accepts one command, made of an address, a read/write select, per-lane write enables and three chip enables. A read returns its word two enabled edges after its command. A write has its data taken from the data-in bus two enabled edges after its command. The write data therefore sits in the same bus slot that a read's data would use.

A write can still be in flight when a later read asks for the same address. The block forwards the lanes of that pending write into the read result, merged with the lanes already stored. A clock-enable input freezes the whole block. A deselect, or a write slot, or the output-enable pin keeps the read-data drive low. The bus is split into data-in, data-out and a drive-enable signal, so that the design stays synthesizable.

Top module: `ztsram`

## Requirements
- R1: At an enabled edge with the device selected, `rdWrN` = 0 marks a write. The address and byte enables of that write are registered on that same edge.
- R2: The write data of a command is sampled from `wrData` on the second enabled edge after the command edge. Data on `wrData` at any other edge is never stored.
- R3: A read command presents the stored word on `rdData` with `rdDrive` high after the second enabled edge following the command. The word stays there until the next enabled edge.
- R4: Reads and writes may be issued on consecutive edges in any order. A read always returns the newest data of every earlier write, including a write whose data arrives only one edge before the read's array access.
- R5: `byteWrN` is active low, and bit i controls lane i, which is `wrData[i*LANE_W +: LANE_W]`. Lanes whose bit is high keep their old contents, and all bits low writes the whole word.
- R6: While `holdEn` is high, no command is accepted, no pipeline stage advances, no write data is stored, and `rdData`/`rdDrive` keep their values.
- R7: The device is selected only when `chipEn0` = 1, `chipEn1N` = 0 and `chipEn2N` = 0. A deselected edge is a no-operation: its bus slot two enabled edges later has `rdDrive` low. Commands already in flight still complete.
- R8: `rdDrive` is high only in the bus slot of a read while `outEnN` is low. `outEnN` acts without a clock edge. A write slot never drives, whatever the level of `outEnN`.
- R9: After reset, all pipeline stages are empty and `rdDrive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| holdEn | input | 1 | High freezes the whole block for that edge |
| chipEn0 | input | 1 | Chip enable, active high |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2N | input | 1 | Chip enable, active low |
| rdWrN | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address of the command |
| byteWrN | input | LANES | Per-lane write enables, active low |
| wrData | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| outEnN | input | 1 | Output enable, active low, not clocked |
| rdData | output | LANES*LANE_W | Read data |
| rdDrive | output | 1 | High when `rdData` should be driven onto the bus |

## Verification
The bench builds the block with ADDR_W = 3, LANE_W = 9 and LANES = 2, which gives eight 18-bit words. With that size it can fill and read back every address, and it can apply all four lane-mask patterns to every address. The small address space makes random traffic hit the same word often. Writes followed at distance one or two by reads of the same address are then common, so the forwarding path and the commit path are both exercised over and over, mixed with hold, deselect and output-enable changes.

// File: rtl/ztsram_pkg.sv
`timescale 1ns/1ps
package ztsram_pkg;

  // strobes issued by the control pipeline to the datapath
  typedef struct packed {
    logic advance;   // enabled edge: pipeline moves
    logic rdEn;      // stage-1 read accesses the array
    logic wrCommit;  // stage-2 write stores bus data
    logic bypass;    // stage-2 write targets the stage-1 read address
  } strobes_t;

endpackage

// File: rtl/ztsram_ctrl.sv
`timescale 1ns/1ps
module ztsram_ctrl
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              holdEn,
  input  logic              chipEn0,
  input  logic              chipEn1N,
  input  logic              chipEn2N,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              outEnN,
  output strobes_t          str,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrBe,
  output logic              rdDrive
);

  logic              selected;
  logic              s1Valid, s1Read;
  logic [ADDR_W-1:0] s1Addr;
  logic [LANES-1:0]  s1Be;
  logic              s2Valid, s2Read;
  logic [ADDR_W-1:0] s2Addr;
  logic [LANES-1:0]  s2Be;
  logic              outValid;

  assign selected = chipEn0 & ~chipEn1N & ~chipEn2N;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      s1Read   <= 1'b0;
      s1Addr   <= '0;
      s1Be     <= '0;
      s2Valid  <= 1'b0;
      s2Read   <= 1'b0;
      s2Addr   <= '0;
      s2Be     <= '0;
      outValid <= 1'b0;
    end else if (!holdEn) begin
      s1Valid  <= selected;
      s1Read   <= rdWrN;
      s1Addr   <= addr;
      s1Be     <= ~byteWrN;
      s2Valid  <= s1Valid;
      s2Read   <= s1Read;
      s2Addr   <= s1Addr;
      s2Be     <= s1Be;
      outValid <= s2Valid & s2Read;
    end
  end

  always_comb begin
    str.advance  = ~holdEn;
    str.rdEn     = ~holdEn & s1Valid & s1Read;
    str.wrCommit = ~holdEn & s2Valid & ~s2Read;
    str.bypass   = ~holdEn & s1Valid & s1Read & s2Valid & ~s2Read
                   & (s1Addr == s2Addr);
  end

  assign rdAddr  = s1Addr;
  assign wrAddr  = s2Addr;
  assign wrBe    = s2Be;
  assign rdDrive = outValid & ~outEnN;

  // R1
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!holdEn && selected && !rdWrN) |=> (s1Valid && !s1Read && s1Addr == $past(addr)));

  // R7
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!holdEn && !selected) |=> !s1Valid);

  // R8
  write_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.wrCommit |=> !rdDrive);

  // R6
  hold_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdEn |=> ($stable(s1Valid) && $stable(s2Valid) && $stable(outValid)));

endmodule

// File: rtl/ztsram_dpath.sv
`timescale 1ns/1ps
module ztsram_dpath
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobes_t                str,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        wrBe,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] stored;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] ramQ;
  logic [WORD_W-1:0] rdDataQ;

  assign stored = mem[rdAddr];

  // forward the lanes of the write being stored on this same edge
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = (str.bypass && wrBe[l])
                                      ? wrData[l*LANE_W +: LANE_W]
                                      : stored[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (str.wrCommit) begin
      for (int l = 0; l < LANES; l++) begin
        if (wrBe[l]) mem[wrAddr][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramQ    <= '0;
      rdDataQ <= '0;
    end else begin
      if (str.rdEn)    ramQ    <= merged;
      if (str.advance) rdDataQ <= ramQ;
    end
  end

  assign rdData = rdDataQ;

  // R6
  hold_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !str.advance |=> $stable(rdDataQ));

  // R4
  bypass_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.bypass |-> (str.wrCommit && str.rdEn));

endmodule

// File: rtl/ztsram.sv
`timescale 1ns/1ps
module ztsram
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    holdEn,
  input  logic                    chipEn0,
  input  logic                    chipEn1N,
  input  logic                    chipEn2N,
  input  logic                    rdWrN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        byteWrN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  strobes_t          str;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  wrBe;

  ztsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .holdEn(holdEn),
    .chipEn0(chipEn0), .chipEn1N(chipEn1N), .chipEn2N(chipEn2N),
    .rdWrN(rdWrN), .addr(addr), .byteWrN(byteWrN), .outEnN(outEnN),
    .str(str), .rdAddr(rdAddr), .wrAddr(wrAddr), .wrBe(wrBe),
    .rdDrive(rdDrive)
  );

  ztsram_dpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .str(str),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrBe(wrBe),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/ztsram_test.sv
`timescale 1ns/1ps
module ztsram_test;

  localparam int AW = 3;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int WW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          holdEn = 1'b0;
  logic          chipEn0 = 1'b0, chipEn1N = 1'b1, chipEn2N = 1'b1;
  logic          rdWrN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] byteWrN = '1;
  logic [WW-1:0] wrData = '0;
  logic          outEnN = 1'b0;
  logic [WW-1:0] rdData;
  logic          rdDrive;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [WW-1:0] mdl [1<<AW];
  logic          m1v = 0, m1r = 0, m2v = 0, m2r = 0, expV = 0;
  logic [AW-1:0] m1a = '0, m2a = '0;
  logic [NL-1:0] m1b = '0, m2b = '0;
  logic [WW-1:0] m1d = '0, m2d = '0, expD = '0;
  logic [31:0]   lfsr = 32'hACE1_1234;

  always #4 clk = ~clk;

  ztsram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .holdEn(holdEn),
    .chipEn0(chipEn0), .chipEn1N(chipEn1N), .chipEn2N(chipEn2N),
    .rdWrN(rdWrN), .addr(addr), .byteWrN(byteWrN), .wrData(wrData),
    .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic checkVal(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, edge, update model, check at next negedge
  task automatic cyc(input logic hold, input logic [2:0] ce, input logic rw,
                     input logic [AW-1:0] a, input logic [NL-1:0] bwn,
                     input logic [WW-1:0] d, input logic oen, input string tag);
    logic sel;
    holdEn = hold;
    {chipEn0, chipEn1N, chipEn2N} = ce;
    rdWrN = rw; addr = a; byteWrN = bwn; outEnN = oen;
    if (hold) wrData = ~m2d ^ 18'h2AAAA;
    else if (m2v && !m2r) wrData = m2d;
    else wrData = 18'h15A5A;
    sel = ce[2] & ~ce[1] & ~ce[0];
    @(posedge clk);
    if (!hold) begin
      expV = m2v && m2r;
      if (m2v && m2r) expD = mdl[m2a];
      if (m2v && !m2r)
        for (int l = 0; l < NL; l++)
          if (m2b[l]) mdl[m2a][l*LW +: LW] = m2d[l*LW +: LW];
      m2v = m1v; m2r = m1r; m2a = m1a; m2b = m1b; m2d = m1d;
      m1v = sel; m1r = rw; m1a = a; m1b = ~bwn; m1d = d;
    end
    @(negedge clk);
    checkVal({tag, " drive"}, {17'b0, rdDrive}, {17'b0, expV && !oen});
    if (expV && !oen) checkVal({tag, " data"}, rdData, expD);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bwn, input logic [WW-1:0] d, input string tag);
    cyc(1'b0, 3'b100, 1'b0, a, bwn, d, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, 3'b100, 1'b1, a, 2'b11, 18'h0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 3'b000, 1'b1, '0, 2'b11, 18'h0, 1'b0, tag);
  endtask

  task automatic runAll;
    for (int i = 0; i < (1<<AW); i++) mdl[i] = '0;
    // R9: reset state
    repeat (3) @(negedge clk);
    checkVal("R9 drive in reset", {17'b0, rdDrive}, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    checkVal("R9 drive after reset", {17'b0, rdDrive}, 18'h0);

    // R1 / R2: fill every word with a full write
    for (int a = 0; a < (1<<AW); a++)
      wr(a[AW-1:0], 2'b00, 18'(a * 18'h2345 ^ 18'h1F0F), "R1");
    idle("R2"); idle("R2");
    // R3: read every word back
    for (int a = 0; a < (1<<AW); a++) rd(a[AW-1:0], "R3");
    idle("R3"); idle("R3");

    // R5: every lane mask on every address, read right behind it
    for (int a = 0; a < (1<<AW); a++)
      for (int p = 0; p < 4; p++) begin
        wr(a[AW-1:0], p[1:0], 18'(a * 18'h0111 + p * 18'h3C3C5), "R5");
        rd(a[AW-1:0], "R5");
      end
    idle("R5"); idle("R5");

    // R4: explicit distances 1, 2 and 3 between write and read of one word
    wr(3'd5, 2'b00, 18'h12345, "R4"); rd(3'd5, "R4");
    wr(3'd5, 2'b01, 18'h2ABCD, "R4"); idle("R4"); rd(3'd5, "R4");
    wr(3'd5, 2'b10, 18'h0F0F0, "R4"); idle("R4"); idle("R4"); rd(3'd5, "R4");
    rd(3'd2, "R4"); wr(3'd2, 2'b00, 18'h3FFFF, "R4"); rd(3'd2, "R4");
    // R4: random back-to-back mix
    for (int i = 0; i < 300; i++) begin
      lfsr = nextRand(lfsr);
      cyc(1'b0, 3'b100, lfsr[0], lfsr[3:1], lfsr[5:4], lfsr[23:6], 1'b0, "R4");
    end

    // R6: random holds with junk on every input during the hold
    for (int i = 0; i < 300; i++) begin
      lfsr = nextRand(lfsr);
      cyc(lfsr[7] & lfsr[8], 3'b100, lfsr[0], lfsr[3:1], lfsr[5:4], lfsr[25:8], 1'b0, "R6");
    end

    // R7: each chip enable deselects on its own
    for (int i = 0; i < 300; i++) begin
      lfsr = nextRand(lfsr);
      cyc(1'b0, (lfsr[9] ? 3'b100 : lfsr[12:10]), lfsr[0], lfsr[3:1], lfsr[5:4], lfsr[27:10], 1'b0, "R7");
    end

    // R8: output enable varied across reads and writes
    for (int i = 0; i < 300; i++) begin
      lfsr = nextRand(lfsr);
      cyc(1'b0, 3'b100, lfsr[0], lfsr[3:1], lfsr[5:4], lfsr[26:9], lfsr[30], "R8");
    end
    // R8: outEnN acts inside a cycle without a clock edge
    wr(3'd1, 2'b00, 18'h2468A, "R8"); idle("R8"); rd(3'd1, "R8"); idle("R8");
    idle("R8");
    outEnN = 1'b1; #1;
    checkVal("R8 async off", {17'b0, rdDrive}, 18'h0);
    outEnN = 1'b0; #1;
    checkVal("R8 async on", {17'b0, rdDrive}, {17'b0, expV});
    repeat (3) idle("R8");
  endtask

  initial begin
    fork
      runAll();
      begin
        #(8 * 50000);
        fails++;
        $display("FAIL R9 watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule